// File: doc/BRIEF.md
# ADC Reference Saturation Calibration Loop

This block trims the reference level of a pair of 3-bit converters that digitise the in-phase (I) and quadrature (Q) channels of a receiver. It watches the converter output codes. It counts how many samples land on a full-scale code, and it nudges a digital reference-adjust word up or down so that clipping happens a set share of the time. With the reference held this way, the 3-bit quantizer stays well used while the gain of the RF and IF stages drifts slowly with temperature and component spread.

The loop is deliberately slow. It decides only once per window of accepted samples, and each decision moves the reference word by a single step. The window length is programmable, so at a sample rate of tens of MHz a long window gives a time constant of seconds. The reference word is clamped at both ends of its range. That range corresponds to a bounded span of about ±4 dB of input level. The block regulates clipping frequency, not mean amplitude, so it is not a fast gain control.

The block sees a sample strobe, the two codes, the window length and a pair of count thresholds. It drives the reference-adjust word, which would feed the converter reference generator.

Top module: `adc_satcal`

## Requirements
- R1: While `rst` is high, and after it is released until the first window ends, `ref_code` equals mid-range, `1 << (REF_W-1)`. Reset also clears the sample and saturation counters, so the first window after reset starts empty.
- R2: Codes are two's complement. A sample counts as saturated when `i_code` or `q_code` equals the most positive code (3'b011 for 3 bits) or the most negative code (3'b100). All other codes count as not saturated.
- R3: A window is `win_len + 1` accepted samples. Cycles with `smp_vld` low do not advance the window or the count, and they never change `ref_code`, whatever the codes are.
- R4: At the end of a window, if the saturated count exceeds `thr_hi`, `ref_code` rises by one. The new value is visible after the clock edge that accepts the window's last sample.
- R5: At the end of a window, if the saturated count is below `thr_lo` and not above `thr_hi`, `ref_code` falls by one on that same edge.
- R6: If the count is neither above `thr_hi` nor below `thr_lo`, `ref_code` holds. When both conditions are true, the step up wins.
- R7: `ref_code` saturates at all-ones and at zero. A step beyond either limit leaves it unchanged and never wraps.
- R8: `ref_code` changes only at a window end, and by at most one per window. It is steady through the samples before the last one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | Strobe: an I/Q sample pair is present this cycle |
| i_code | input | CODE_W | In-phase converter code, two's complement |
| q_code | input | CODE_W | Quadrature converter code, two's complement |
| win_len | input | WIN_W | Window length minus one, in accepted samples |
| thr_hi | input | WIN_W+1 | Count above which the reference steps up |
| thr_lo | input | WIN_W+1 | Count below which the reference steps down |
| ref_code | output | REF_W | Reference-adjust word, clamped |

## Verification
A reference update is due on the clock edge that accepts a window's last sample. It is registered once, with no further pipeline. The bench drives each sample on a falling edge and reads `ref_code` on the falling edge right after the edge that took the final sample. It also reads `ref_code` just before driving the last sample, to confirm that nothing moved inside the window. Idle cycles with clipping codes are inserted between samples, and afterwards `ref_code` is read on the next falling edge to show that it did not move.

// File: rtl/satcal_pkg.sv
package satcal_pkg;
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;
endpackage

// File: rtl/satcal_sat_detect.sv
module satcal_sat_detect #(
    parameter int CODE_W = 3
) (
    input  logic [CODE_W-1:0] code,
    output logic              sat
);
    localparam logic [CODE_W-1:0] POS_FS = {1'b0, {(CODE_W-1){1'b1}}};
    localparam logic [CODE_W-1:0] NEG_FS = {1'b1, {(CODE_W-1){1'b0}}};

    always_comb begin
        sat = (code == POS_FS) || (code == NEG_FS);
    end
endmodule

// File: rtl/satcal_window.sv
module satcal_window
    import satcal_pkg::*;
#(
    parameter int WIN_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_vld,
    input  logic             smp_sat,
    input  logic [WIN_W-1:0] win_len,
    input  logic [WIN_W:0]   thr_hi,
    input  logic [WIN_W:0]   thr_lo,
    output step_e            step
);
    typedef struct packed {
        logic [WIN_W-1:0] cnt;
        logic [WIN_W:0]   sat_cnt;
    } win_st_t;

    win_st_t    st_d, st_q;
    logic [WIN_W:0] total;
    logic       last;

    always_comb begin
        st_d  = st_q;
        step  = STEP_HOLD;
        total = st_q.sat_cnt + {{WIN_W{1'b0}}, smp_sat};
        last  = (st_q.cnt == win_len);
        if (smp_vld) begin
            if (last) begin
                st_d.cnt     = '0;
                st_d.sat_cnt = '0;
                if (total > thr_hi) begin
                    step = STEP_UP;
                end else if (total < thr_lo) begin
                    step = STEP_DOWN;
                end
            end else begin
                st_d.cnt     = st_q.cnt + 1'b1;
                st_d.sat_cnt = total;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/satcal_ref.sv
module satcal_ref
    import satcal_pkg::*;
#(
    parameter int REF_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  step_e            step,
    output logic [REF_W-1:0] ref_code
);
    localparam logic [REF_W-1:0] REF_MAX = {REF_W{1'b1}};
    localparam logic [REF_W-1:0] REF_MID = {1'b1, {(REF_W-1){1'b0}}};

    typedef struct packed {
        logic [REF_W-1:0] lvl;
    } ref_st_t;

    ref_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (step)
            STEP_UP:   if (st_q.lvl != REF_MAX) st_d.lvl = st_q.lvl + 1'b1;
            STEP_DOWN: if (st_q.lvl != '0)      st_d.lvl = st_q.lvl - 1'b1;
            default:   st_d = st_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.lvl <= REF_MID;
        end else begin
            st_q <= st_d;
        end
    end

    assign ref_code = st_q.lvl;
endmodule

// File: rtl/adc_satcal.sv
module adc_satcal
    import satcal_pkg::*;
#(
    parameter int CODE_W = 3,
    parameter int WIN_W  = 12,
    parameter int REF_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_vld,
    input  logic [CODE_W-1:0] i_code,
    input  logic [CODE_W-1:0] q_code,
    input  logic [WIN_W-1:0]  win_len,
    input  logic [WIN_W:0]    thr_hi,
    input  logic [WIN_W:0]    thr_lo,
    output logic [REF_W-1:0]  ref_code
);
    localparam int NCH = 2;

    logic [NCH-1:0][CODE_W-1:0] ch_code;
    logic [NCH-1:0]             ch_sat;
    logic                       smp_sat;
    step_e                      step;

    assign ch_code[0] = i_code;
    assign ch_code[1] = q_code;

    for (genvar g = 0; g < NCH; g++) begin : g_det
        satcal_sat_detect #(.CODE_W(CODE_W)) u_det (
            .code (ch_code[g]),
            .sat  (ch_sat[g])
        );
    end

    assign smp_sat = |ch_sat;

    satcal_window #(.WIN_W(WIN_W)) u_win (
        .clk     (clk),
        .rst     (rst),
        .smp_vld (smp_vld),
        .smp_sat (smp_sat),
        .win_len (win_len),
        .thr_hi  (thr_hi),
        .thr_lo  (thr_lo),
        .step    (step)
    );

    satcal_ref #(.REF_W(REF_W)) u_ref (
        .clk      (clk),
        .rst      (rst),
        .step     (step),
        .ref_code (ref_code)
    );
endmodule

// File: rtl/satcal_chk.sv
module satcal_chk #(
    parameter int WIN_W = 12,
    parameter int REF_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             smp_vld,
    input logic [WIN_W-1:0] win_len,
    input logic [REF_W-1:0] ref_code
);
    localparam logic [REF_W-1:0] REF_MAX = {REF_W{1'b1}};
    localparam logic [REF_W-1:0] REF_MID = {1'b1, {(REF_W-1){1'b0}}};

    logic [WIN_W-1:0] seen_q;
    logic             at_end;

    assign at_end = smp_vld && (seen_q == win_len);

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= '0;
        end else if (smp_vld) begin
            seen_q <= at_end ? '0 : seen_q + 1'b1;
        end
    end

    AST_RESET_MID: assert property (@(posedge clk)
        rst |=> (ref_code == REF_MID)); // R1

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !smp_vld |=> $stable(ref_code)); // R3

    AST_STEP_AT_WIN_END: assert property (@(posedge clk) disable iff (rst)
        !$stable(ref_code) |-> $past(at_end)); // R8

    AST_UNIT_STEP: assert property (@(posedge clk) disable iff (rst)
        !$stable(ref_code) |-> ((ref_code == $past(ref_code) + 1'b1) ||
                                (ref_code == $past(ref_code) - 1'b1))); // R8

    AST_TOP_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        ($past(ref_code) == REF_MAX) |-> (ref_code != '0)); // R7

    AST_BOTTOM_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        ($past(ref_code) == '0) |-> (ref_code != REF_MAX)); // R7
endmodule

bind adc_satcal satcal_chk #(.WIN_W(WIN_W), .REF_W(REF_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .smp_vld  (smp_vld),
    .win_len  (win_len),
    .ref_code (ref_code)
);

// File: tb/adc_satcal_bench.sv
module adc_satcal_bench;
    localparam int CODE_W = 3;
    localparam int WIN_W  = 4;
    localparam int REF_W  = 3;
    localparam int RMAX   = (1 << REF_W) - 1;
    localparam int RMID   = 1 << (REF_W - 1);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              smp_vld = 1'b0;
    logic [CODE_W-1:0] i_code = '0;
    logic [CODE_W-1:0] q_code = '0;
    logic [WIN_W-1:0]  win_len = '0;
    logic [WIN_W:0]    thr_hi = '0;
    logic [WIN_W:0]    thr_lo = '0;
    logic [REF_W-1:0]  ref_code;

    int checks = 0;
    int errors = 0;
    int exp_ref = RMID;
    bit done = 1'b0;

    always #5 clk = ~clk;

    adc_satcal #(.CODE_W(CODE_W), .WIN_W(WIN_W), .REF_W(REF_W)) u_adc_satcal (
        .clk(clk), .rst(rst), .smp_vld(smp_vld), .i_code(i_code), .q_code(q_code),
        .win_len(win_len), .thr_hi(thr_hi), .thr_lo(thr_lo), .ref_code(ref_code)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: ref_code=%0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int nonsat_code(input int x);
        return (x % 6 < 3) ? (x % 6) : (x % 6) + 2;
    endfunction

    function automatic void model(input int cnt, input int hi, input int lo);
        if (cnt > hi) begin
            if (exp_ref < RMAX) exp_ref++;
        end else if (cnt < lo) begin
            if (exp_ref > 0) exp_ref--;
        end
    endfunction

    task automatic run_window(input string req, input int n, input int k, input bit gap);
        for (int j = 0; j < n; j++) begin
            @(negedge clk);
            if (j == n - 1 && n > 1) check("R8", int'(ref_code), exp_ref);
            smp_vld = 1'b1;
            if (j < k) begin
                case (j % 3)
                    0:       begin i_code = 3'b011; q_code = 3'b000; end
                    1:       begin i_code = 3'b001; q_code = 3'b100; end
                    default: begin i_code = 3'b100; q_code = 3'b011; end
                endcase
            end else begin
                i_code = 3'(nonsat_code(j));
                q_code = 3'(nonsat_code(j + 1));
            end
            if (gap) begin
                @(negedge clk);
                smp_vld = 1'b0;
                i_code  = 3'b011;
                q_code  = 3'b100;
            end
        end
        @(negedge clk);
        smp_vld = 1'b0;
        model(k, int'(thr_hi), int'(thr_lo));
        check(req, int'(ref_code), exp_ref);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung, ref_code=%0d expected %0d", ref_code, exp_ref);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        check("R1", int'(ref_code), RMID);
        rst = 1'b0;
        @(negedge clk);
        check("R1", int'(ref_code), RMID);

        // R2: every I/Q pair, one-sample windows, hi=0 lo=1
        win_len = 0; thr_hi = 0; thr_lo = 1;
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                @(negedge clk);
                smp_vld = 1'b1;
                i_code = 3'(a);
                q_code = 3'(b);
                @(negedge clk);
                smp_vld = 1'b0;
                model((a == 3 || a == 4 || b == 3 || b == 4) ? 1 : 0, 0, 1);
                check("R2", int'(ref_code), exp_ref);
            end
        end

        // R3: idle cycles carrying clipping codes are not counted
        win_len = 3; thr_hi = 2; thr_lo = 1;
        @(negedge clk);
        smp_vld = 1'b0; i_code = 3'b011; q_code = 3'b100;
        repeat (8) @(negedge clk);
        check("R3", int'(ref_code), exp_ref);
        run_window("R3", 4, 0, 1'b1);
        run_window("R3", 4, 4, 1'b1);

        // R4/R5/R6: sweep of window lengths and saturated counts
        for (int w = 0; w < 4; w++) begin
            int n;
            n = (w == 0) ? 2 : (w == 1) ? 5 : (w == 2) ? 8 : 16;
            win_len = WIN_W'(n - 1);
            thr_lo = (WIN_W+1)'(n / 4);
            thr_hi = (WIN_W+1)'(n / 2);
            for (int k = 0; k <= n; k++) begin
                run_window((k > n / 2) ? "R4" : (k < n / 4) ? "R5" : "R6", n, k, 1'b0);
            end
        end

        // R6: overlapping thresholds, step up has priority
        win_len = 7; thr_hi = 2; thr_lo = 6;
        for (int k = 0; k <= 8; k++) run_window("R6", 8, k, k[0]);

        // R7: drive to both limits and beyond
        win_len = 3; thr_hi = 0; thr_lo = 0;
        for (int r = 0; r < 10; r++) run_window("R7", 4, 4, 1'b0);
        check("R7", int'(ref_code), RMAX);
        thr_hi = 4; thr_lo = 1;
        for (int r = 0; r < 10; r++) run_window("R7", 4, 0, 1'b0);
        check("R7", int'(ref_code), 0);

        // R1: reset returns to mid-range
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        exp_ref = RMID;
        @(negedge clk);
        check("R1", int'(ref_code), RMID);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule